// File: doc/BRIEF.md
# Oscillation Test Session Controller

This block is the central timer of an on-chip interconnect test that uses oscillating rings. On a start command it raises a single enable that lets every local ring counter run. It counts system-clock cycles up to a programmed window length n and then drops the enable, so all local counters freeze together. A ring's frequency is then the system clock frequency times its local count divided by n.

Once the window has closed, the controller clocks the frozen local counts out of a serial chain, one fixed-width word per ring. It judges each word against programmed lower and upper count limits. These limits are the band's frequency limits multiplied by the window duration. A count of zero means the ring never oscillated, which points to a stuck-at or open fault. Each verdict is presented as a 2-bit code with the ring index, and any non-pass verdict sets a sticky fail flag. The flag holds until the next session starts.

Top module: `osc_session_ctrl`

## Requirements
- R1: After reset, osc_en_o, ring_shift_o, res_vld_o, fail_o and done_o are all 0.
- R2: A start_i seen high at a clock edge while idle, with a nonzero window length n, raises osc_en_o from that edge on. osc_en_o then stays high for exactly n consecutive cycles.
- R3: start_i is ignored whenever the controller is not idle. Window length, shift count, verdicts and the fail flag are unaffected by it.
- R4: A window length of 0 closes the window at once. osc_en_o never rises, and ring_shift_o is high in the first cycle after the start edge.
- R5: ring_shift_o rises in the cycle osc_en_o falls and stays high for exactly N_RINGS*CNT_W consecutive cycles. ring_sdata_i is sampled at every edge where ring_shift_o is high. Each word is read MSB first, and ring 0 comes first.
- R6: After every CNT_W-th sample, res_vld_o is high for one cycle, with res_ring_o giving the ring index and res_code_o giving the verdict. Code 01 means the count is zero, and this check has priority. Code 10 means the count is below the lower limit. Code 11 means the count is above the upper limit. Code 00 means the count lies within the limits, inclusive.
- R7: fail_o is cleared by an accepted start and set by any nonzero verdict. Apart from that it holds its value.
- R8: done_o is high for one cycle directly after the last shift cycle. The controller is then idle and accepts a new start.
- R9: Window length and limits are captured when a start is accepted. Changing the inputs during a session has no effect on that session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start command |
| win_len_i | input | WIN_W | Window length n in system clocks |
| cnt_min_i | input | CNT_W | Lowest passing count |
| cnt_max_i | input | CNT_W | Highest passing count |
| ring_sdata_i | input | 1 | Serial data from the local counter chain |
| osc_en_o | output | 1 | Oscillation-test enable for all rings and local counters |
| ring_shift_o | output | 1 | Shift strobe for the local counter chain |
| res_vld_o | output | 1 | Verdict valid strobe |
| res_code_o | output | 2 | Verdict code |
| res_ring_o | output | RING_W | Ring index of the verdict |
| fail_o | output | 1 | Sticky fail flag |
| done_o | output | 1 | Session complete pulse |

## Verification
The bench sweeps every possible count value through each ring position. It runs these sweeps under tight, wide and single-value limit bands, with window lengths of 0, 1, 2, 5 and the maximum. These sweeps catch an off-by-one window (enable held n±1 cycles), a comparator that treats a limit as exclusive, and a zero count reported as slow instead of stuck. A zero-length window that wrapped to the full range would show up as a long enable pulse. A bit order or ring order error would give wrong verdicts in the count sweep. Extra start pulses during the window and during shifting check that a busy controller does not restart or clear its fail flag. Inputs are scrambled after every start to catch limits that are read live rather than captured.

// File: rtl/osc_sess_pkg.sv
package osc_sess_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_DONE   = 2'd3
  } sess_state_e;

  typedef enum logic [1:0] {
    RES_PASS  = 2'b00,
    RES_STUCK = 2'b01,
    RES_SLOW  = 2'b10,
    RES_FAST  = 2'b11
  } ring_res_e;
endpackage

// File: rtl/osc_win_timer.sv
module osc_win_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             close_o
);
  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + WIN_W'(1);
  end

  assign close_o = run_i && (cnt_q == len_i - WIN_W'(1));

  // R2
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_i));
endmodule

// File: rtl/osc_count_deser.sv
module osc_count_deser #(
  parameter int CNT_W   = 12,
  parameter int N_RINGS = 4,
  localparam int BIT_W  = (CNT_W > 1) ? $clog2(CNT_W) : 1,
  localparam int RING_W = (N_RINGS > 1) ? $clog2(N_RINGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              sdata_i,
  output logic [CNT_W-1:0]  word_o,
  output logic              word_vld_o,
  output logic [RING_W-1:0] ring_o,
  output logic              last_o
);
  logic [CNT_W-1:0]  sreg_q;
  logic [BIT_W-1:0]  bit_q;
  logic [RING_W-1:0] ring_q;

  // current bit completes the word on the final strobe
  assign word_o     = {sreg_q[CNT_W-2:0], sdata_i};
  assign word_vld_o = shift_i && (bit_q == BIT_W'(CNT_W - 1));
  assign ring_o     = ring_q;
  assign last_o     = word_vld_o && (ring_q == RING_W'(N_RINGS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      bit_q  <= '0;
      ring_q <= '0;
    end else if (clr_i) begin
      bit_q  <= '0;
      ring_q <= '0;
    end else if (shift_i) begin
      sreg_q <= word_o;
      if (word_vld_o) begin
        bit_q  <= '0;
        ring_q <= ring_q + RING_W'(1);
      end else begin
        bit_q  <= bit_q + BIT_W'(1);
      end
    end
  end

  // R5
  ring_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (ring_q <= RING_W'(N_RINGS - 1)));
endmodule

// File: rtl/osc_classifier.sv
module osc_classifier
  import osc_sess_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  output ring_res_e        res_o
);
  always_comb begin
    if (count_i == '0)         res_o = RES_STUCK;
    else if (count_i < min_i)  res_o = RES_SLOW;
    else if (count_i > max_i)  res_o = RES_FAST;
    else                       res_o = RES_PASS;
  end
endmodule

// File: rtl/osc_session_ctrl.sv
module osc_session_ctrl
  import osc_sess_pkg::*;
#(
  parameter int WIN_W   = 16,
  parameter int CNT_W   = 12,
  parameter int N_RINGS = 4,
  localparam int RING_W = (N_RINGS > 1) ? $clog2(N_RINGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [CNT_W-1:0]  cnt_min_i,
  input  logic [CNT_W-1:0]  cnt_max_i,
  input  logic              ring_sdata_i,
  output logic              osc_en_o,
  output logic              ring_shift_o,
  output logic              res_vld_o,
  output logic [1:0]        res_code_o,
  output logic [RING_W-1:0] res_ring_o,
  output logic              fail_o,
  output logic              done_o
);
  sess_state_e       state_q;
  logic [WIN_W-1:0]  len_q;
  logic [CNT_W-1:0]  min_q, max_q;
  logic              start_ok;
  logic              win_close;
  logic [CNT_W-1:0]  word;
  logic              word_vld, word_last;
  logic [RING_W-1:0] word_ring;
  ring_res_e         verdict;
  ring_res_e         code_q;
  logic [RING_W-1:0] ring_q;
  logic              vld_q, fail_q;

  assign start_ok = (state_q == ST_IDLE) && start_i;

  osc_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_ok),
    .run_i   (state_q == ST_WINDOW),
    .len_i   (len_q),
    .close_o (win_close)
  );

  osc_count_deser #(.CNT_W(CNT_W), .N_RINGS(N_RINGS)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_ok),
    .shift_i    (state_q == ST_SHIFT),
    .sdata_i    (ring_sdata_i),
    .word_o     (word),
    .word_vld_o (word_vld),
    .ring_o     (word_ring),
    .last_o     (word_last)
  );

  osc_classifier #(.CNT_W(CNT_W)) u_class (
    .count_i (word),
    .min_i   (min_q),
    .max_i   (max_q),
    .res_o   (verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      min_q   <= '0;
      max_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          len_q   <= win_len_i;
          min_q   <= cnt_min_i;
          max_q   <= cnt_max_i;
          // zero-length window skips straight to readout
          state_q <= (win_len_i == '0) ? ST_SHIFT : ST_WINDOW;
        end
        ST_WINDOW: if (win_close) state_q <= ST_SHIFT;
        ST_SHIFT:  if (word_last) state_q <= ST_DONE;
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      code_q <= RES_PASS;
      ring_q <= '0;
      fail_q <= 1'b0;
    end else begin
      vld_q <= word_vld;
      if (word_vld) begin
        code_q <= verdict;
        ring_q <= word_ring;
      end
      if (start_ok)                              fail_q <= 1'b0;
      else if (word_vld && verdict != RES_PASS)  fail_q <= 1'b1;
    end
  end

  assign osc_en_o     = (state_q == ST_WINDOW);
  assign ring_shift_o = (state_q == ST_SHIFT);
  assign done_o       = (state_q == ST_DONE);
  assign res_vld_o    = vld_q;
  assign res_code_o   = code_q;
  assign res_ring_o   = ring_q;
  assign fail_o       = fail_q;

  // R5
  win_to_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> ring_shift_o);

  // R6
  res_after_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> $past(ring_shift_o));

  // R7
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_ok) |=> fail_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !osc_en_o && !ring_shift_o));

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_shift_o && start_i && !word_last) |=> ring_shift_o);
endmodule

// File: tb/osc_session_ctrl_tb_top.sv
module osc_session_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W   = 6;
  localparam int CNT_W   = 4;
  localparam int N_RINGS = 3;
  localparam int RING_W  = 2;
  localparam int CHAIN_W = N_RINGS * CNT_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [WIN_W-1:0] win_len_i = '0;
  logic [CNT_W-1:0] cnt_min_i = '0, cnt_max_i = '0;
  logic ring_sdata_i;
  logic osc_en_o, ring_shift_o, res_vld_o, fail_o, done_o;
  logic [1:0] res_code_o;
  logic [RING_W-1:0] res_ring_o;

  logic [CHAIN_W-1:0] chain = '0;
  logic [CHAIN_W-1:0] load_val = '0;
  logic load_req = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // local counter chain model: MSB out, ring 0 in the top word
  always @(posedge clk_i) begin
    if (load_req)          chain <= load_val;
    else if (ring_shift_o) chain <= chain << 1;
  end
  assign ring_sdata_i = chain[CHAIN_W-1];

  osc_session_ctrl #(.WIN_W(WIN_W), .CNT_W(CNT_W), .N_RINGS(N_RINGS)) dut_i (
    .clk_i, .rst_ni, .start_i, .win_len_i, .cnt_min_i, .cnt_max_i,
    .ring_sdata_i, .osc_en_o, .ring_shift_o, .res_vld_o, .res_code_o,
    .res_ring_o, .fail_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int c, input int mn, input int mx);
    if (c == 0) return 1;
    if (c < mn) return 2;
    if (c > mx) return 3;
    return 0;
  endfunction

  task automatic run_session(input int len, input int mn, input int mx,
                             input int c0, input int c1, input int c2,
                             input int spur_at);
    int cnts[3];
    int en_cnt = 0, sh_cnt = 0, nres = 0, cyc = 0;
    bit prev_en = 1'b0, exp_fail = 1'b0;
    cnts[0] = c0; cnts[1] = c1; cnts[2] = c2;
    for (int i = 0; i < 3; i++) if (exp_code(cnts[i], mn, mx) != 0) exp_fail = 1'b1;
    @(negedge clk_i);
    win_len_i = WIN_W'(len);
    cnt_min_i = CNT_W'(mn);
    cnt_max_i = CNT_W'(mx);
    load_val  = {CNT_W'(c0), CNT_W'(c1), CNT_W'(c2)};
    load_req  = 1'b1;
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
    load_req  = 1'b0;
    // R9: scramble inputs after capture
    win_len_i = ~win_len_i;
    cnt_min_i = ~cnt_min_i;
    cnt_max_i = ~cnt_max_i;
    // R7: accepted start clears the flag
    chk(fail_o == 1'b0, "R7 clear on start", int'(fail_o), 0);
    if (len == 0) chk(ring_shift_o && !osc_en_o, "R4 zero window", int'(ring_shift_o), 1);
    else          chk(osc_en_o, "R2 enable rises", int'(osc_en_o), 1);
    while (1) begin
      if (osc_en_o) en_cnt++;
      if (ring_shift_o) sh_cnt++;
      if (prev_en && !osc_en_o)
        chk(ring_shift_o, "R5 shift follows window", int'(ring_shift_o), 1);
      if (res_vld_o) begin
        if (nres < 3) begin
          chk(int'(res_ring_o) == nres, "R6 ring index", int'(res_ring_o), nres);
          chk(int'(res_code_o) == exp_code(cnts[nres], mn, mx), "R6 R9 verdict",
              int'(res_code_o), exp_code(cnts[nres], mn, mx));
        end
        nres++;
      end
      if (done_o || cyc > 300) break;
      prev_en = osc_en_o;
      start_i = (cyc == spur_at);   // R3 spurious start while busy
      cyc++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o, "R8 done reached", int'(done_o), 1);
    chk(en_cnt == len, "R2 R4 R9 window length", en_cnt, len);
    chk(sh_cnt == CHAIN_W, "R3 R5 shift count", sh_cnt, CHAIN_W);
    chk(nres == N_RINGS, "R6 verdict count", nres, N_RINGS);
    chk(fail_o == exp_fail, "R3 R7 sticky fail", int'(fail_o), int'(exp_fail));
    @(negedge clk_i);
    chk(!done_o && !osc_en_o && !ring_shift_o, "R8 single done then idle",
        int'(done_o), 0);
    chk(fail_o == exp_fail, "R7 fail held in idle", int'(fail_o), int'(exp_fail));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lens[5];
    int mns[3];
    int mxs[3];
    lens[0] = 0; lens[1] = 1; lens[2] = 2; lens[3] = 5; lens[4] = 63;
    mns[0] = 3; mxs[0] = 12;
    mns[1] = 1; mxs[1] = 15;
    mns[2] = 6; mxs[2] = 6;
    repeat (3) @(negedge clk_i);
    // R1
    chk(!osc_en_o && !ring_shift_o && !res_vld_o && !fail_o && !done_o,
        "R1 reset state", int'({osc_en_o, ring_shift_o, res_vld_o, fail_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!osc_en_o && !ring_shift_o && !done_o, "R1 idle after reset",
        int'({osc_en_o, ring_shift_o, done_o}), 0);
    for (int l = 0; l < 3; l++) begin
      for (int c = 0; c < 16; c++) begin
        int spur;
        spur = (c % 4 == 1) ? 2 : ((c % 4 == 3) ? 8 : -1);
        run_session(lens[c % 5], mns[l], mxs[l], c, (c + 5) % 16, (c + 11) % 16, spur);
      end
    end
    // all-pass session after failures: flag must clear and stay clear
    run_session(4, 2, 14, 2, 14, 9, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule